// File: doc/BRIEF.md
# AUX Channel Transaction Host

This block lets a processor run one request/reply transaction on a display AUX channel at a time through a small word-addressed register file. Software programs a target address, a command word holding the request type and the payload length minus one, and up to sixteen payload bytes packed four to a 32-bit word. It then sets a start bit. While the transaction runs, the block holds a request on a simple link-side port. When the link side answers, the block stores the reply type, the reply byte count, any error flags and, for an acknowledged reply, the returned data words. It then flags completion as a pending interrupt.

If no answer arrives within a programmable number of clock cycles, the block ends the transaction itself and records a timeout. The block also watches a hot-plug-detect input and a sink interrupt pulse. Each of these raises its own write-one-to-clear interrupt bit. One interrupt output is the OR of every pending bit whose enable is set.

Register word addresses: 0 control, 1 target address, 2 status, 3 interrupt pending, 4 interrupt enable, 5 timeout limit, 8 to 11 transmit words, 12 to 15 receive words.

Top module: `auxc_host`

## Requirements
- R1: After reset the control, status, pending and enable registers read 0, the timeout limit reads 1000 (0x3E8), and `irq` and `lnk_req` are low.
- R2: A write to control (address 0) with bit 16 set, while no transaction runs, raises `lnk_req` from the next clock edge. `lnk_cmd` then shows control bits 15:12 and `lnk_addr` shows the address register. `lnk_len` shows control bits 3:0 plus one, or 0 when control bit 8 (address-only) is set. Control bit 16 reads 1 until the transaction ends and reads 0 afterwards.
- R3: `lnk_tx` bits 32i+31:32i equal transmit word i (address 8+i). Byte j of a word sits in bits 8j+7:8j, so payload byte 4i+j is `lnk_tx[8(4i+j)+7 : 8(4i+j)]`.
- R4: A reply (`rsp_valid` while a transaction runs) ends the transaction. It stores `rsp_type` in status bits 19:16 and `rsp_cnt` in status bits 4:0. Only when `rsp_type` is 0 (native ACK) are the receive words 12+i loaded from `rsp_data` bits 32i+31:32i; any other type (1 native NACK, 2 native DEFER, 4 I2C NACK, 8 I2C DEFER) leaves them unchanged.
- R5: Reply error flags are sticky in status: `rsp_err[0]` sets bit 9 (receive error), `rsp_err[1]` sets bit 10 (sink status) and `rsp_err[2]` sets bit 11 (missing stop). Writing ones to status bits 11:8 clears exactly those bits, so writing 0xF00 clears all error bits.
- R6: If no reply arrives within the timeout limit (address 5, counted in cycles from start), the transaction ends on its own: `lnk_req` falls, status bit 8 (timeout) is set and the done interrupt is set.
- R7: While a transaction runs, writes to control, address, timeout limit and transmit words have no effect, and the link-side request fields stay constant.
- R8: Pending bits are bit 0 done, bit 1 sink event, bit 2 plug and bit 3 unplug. Each bit is set by its event, stays set, and is cleared by writing 1 to it at address 3. An event in the same cycle as the clear wins.
- R9: `irq` is high exactly when some pending bit has its enable bit (same position, address 4) set.
- R10: Status bit 28 shows `hpd_in` after a two-flop synchroniser. A rising synchronised level sets the plug bit and a falling level sets the unplug bit.
- R11: A one-cycle pulse on `sink_evt` sets pending bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, OR of enabled pending bits |
| hpd_in | input | 1 | Hot-plug-detect level, asynchronous |
| sink_evt | input | 1 | Sink interrupt event pulse |
| lnk_req | output | 1 | Transaction in progress, request valid |
| lnk_cmd | output | 4 | Request type code |
| lnk_addr | output | 20 | Request target address |
| lnk_len | output | 5 | Payload byte count (0 for address-only) |
| lnk_tx | output | 128 | Packed transmit payload |
| rsp_valid | input | 1 | Reply present for one cycle |
| rsp_type | input | 4 | Reply type code |
| rsp_err | input | 3 | Reply error flags |
| rsp_cnt | input | 5 | Reply byte count |
| rsp_data | input | 128 | Packed reply payload |

## Verification
Directed transactions check the boundaries: a full sixteen-byte write, which fixes the length offset and the byte packing, and an address-only request, which must report length zero. An acknowledged read followed by a refused one shows whether the receive words are loaded only on ACK. A run with no reply separates the timeout path from the reply path. Seeded random transactions then vary length, command, address, payload and reply type, so that a wrong lane, a wrong length offset or a wrong type-to-data gate shows up against values the bench computes itself.

// File: rtl/auxc_pkg.sv
package auxc_pkg;
  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int BYTES  = WORDS * 4;
  localparam int LEN_W  = $clog2(BYTES);
  localparam int CNT_W  = LEN_W + 1;
  localparam int RA_W   = 4;
  localparam int N_INT  = 4;

  localparam logic [RA_W-1:0] RA_CTRL = 4'd0;
  localparam logic [RA_W-1:0] RA_ADDR = 4'd1;
  localparam logic [RA_W-1:0] RA_STAT = 4'd2;
  localparam logic [RA_W-1:0] RA_INT  = 4'd3;
  localparam logic [RA_W-1:0] RA_EN   = 4'd4;
  localparam logic [RA_W-1:0] RA_TMO  = 4'd5;
  localparam logic [RA_W-1:0] RA_TX0  = 4'd8;
  localparam logic [RA_W-1:0] RA_RX0  = 4'd12;

  localparam int CTRL_AONLY = 8;
  localparam int CTRL_CMD   = 12;
  localparam int CTRL_START = 16;
  localparam int STAT_ERR   = 8;
  localparam int STAT_TYPE  = 16;
  localparam int STAT_HPD   = 28;

  localparam int INT_DONE   = 0;
  localparam int INT_SINK   = 1;
  localparam int INT_PLUG   = 2;
  localparam int INT_UNPLUG = 3;

  localparam logic [3:0] RT_NATIVE_ACK = 4'h0;
endpackage

// File: rtl/auxc_txn_ctl.sv
module auxc_txn_ctl #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rsp_valid,
  input  logic [TMO_W-1:0] limit,
  output logic             busy,
  output logic             done,
  output logic             tmo
);
  logic             busy_q, busy_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             expired;

  assign expired = (cnt_q >= limit);
  assign done    = busy_q && (rsp_valid || expired);
  assign tmo     = busy_q && !rsp_valid && expired;
  assign busy    = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);  // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));  // R2
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= limit));  // R6
endmodule

// File: rtl/auxc_irq.sv
module auxc_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_we) pend_d = pend_d & ~clr;
    pend_d = pend_d | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> pend_q[i]);  // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr[i] && !set[i]) |=> !pend_q[i]);  // R8
  end
endmodule

// File: rtl/auxc_hpd_det.sv
module auxc_hpd_det (
  input  logic clk,
  input  logic rst_n,
  input  logic hpd_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= hpd_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q && !s3_q;
  assign fall  = !s2_q && s3_q;

  AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);  // R10
endmodule

// File: rtl/auxc_host.sv
module auxc_host
  import auxc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [RA_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    irq,
  input  logic                    hpd_in,
  input  logic                    sink_evt,
  output logic                    lnk_req,
  output logic [3:0]              lnk_cmd,
  output logic [ADDR_W-1:0]       lnk_addr,
  output logic [CNT_W-1:0]        lnk_len,
  output logic [WORDS*DATA_W-1:0] lnk_tx,
  input  logic                    rsp_valid,
  input  logic [3:0]              rsp_type,
  input  logic [2:0]              rsp_err,
  input  logic [CNT_W-1:0]        rsp_cnt,
  input  logic [WORDS*DATA_W-1:0] rsp_data
);
  logic [LEN_W-1:0]              lm1_q, lm1_d;
  logic [3:0]                    cmd_q, cmd_d;
  logic                          aonly_q, aonly_d;
  logic [ADDR_W-1:0]             addr_q, addr_d;
  logic [TMO_W-1:0]              tmo_q, tmo_d;
  logic [WORDS-1:0][DATA_W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic [3:0]                    err_q, err_d;
  logic [3:0]                    rtype_q, rtype_d;
  logic [CNT_W-1:0]              rcnt_q, rcnt_d;
  logic [N_INT-1:0]              en_q, en_d;

  logic busy, done, tmo_hit, reply, wr_txn, start;
  logic hpd_lvl, hpd_rise, hpd_fall;
  logic [N_INT-1:0] pend, int_set;

  assign wr_txn = bus_wr && !busy;
  assign start  = wr_txn && (bus_addr == RA_CTRL) && bus_wdata[CTRL_START];
  assign reply  = done && !tmo_hit;

  auxc_txn_ctl #(.TMO_W(TMO_W)) u_txn (
    .clk, .rst_n, .start, .rsp_valid, .limit(tmo_q),
    .busy, .done, .tmo(tmo_hit)
  );

  auxc_hpd_det u_hpd (
    .clk, .rst_n, .hpd_in, .level(hpd_lvl), .rise(hpd_rise), .fall(hpd_fall)
  );

  always_comb begin
    int_set             = '0;
    int_set[INT_DONE]   = done;
    int_set[INT_SINK]   = sink_evt;
    int_set[INT_PLUG]   = hpd_rise;
    int_set[INT_UNPLUG] = hpd_fall;
  end

  auxc_irq #(.N(N_INT)) u_irq (
    .clk, .rst_n, .set(int_set),
    .clr_we(bus_wr && (bus_addr == RA_INT)), .clr(bus_wdata[N_INT-1:0]),
    .en(en_q), .pend, .irq
  );

  // Next-state for the register file
  always_comb begin
    lm1_d   = lm1_q;
    cmd_d   = cmd_q;
    aonly_d = aonly_q;
    addr_d  = addr_q;
    tmo_d   = tmo_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    err_d   = err_q;
    rtype_d = rtype_q;
    rcnt_d  = rcnt_q;
    en_d    = en_q;
    if (wr_txn) begin
      if (bus_addr == RA_CTRL) begin
        lm1_d   = bus_wdata[LEN_W-1:0];
        aonly_d = bus_wdata[CTRL_AONLY];
        cmd_d   = bus_wdata[CTRL_CMD +: 4];
      end
      if (bus_addr == RA_ADDR) addr_d = bus_wdata[ADDR_W-1:0];
      if (bus_addr == RA_TMO)  tmo_d  = bus_wdata[TMO_W-1:0];
      for (int i = 0; i < WORDS; i++)
        if (bus_addr == RA_W'(RA_TX0 + i)) tx_d[i] = bus_wdata;
    end
    if (bus_wr && (bus_addr == RA_EN)) en_d = bus_wdata[N_INT-1:0];
    if (bus_wr && (bus_addr == RA_STAT)) err_d = err_q & ~bus_wdata[STAT_ERR +: 4];
    if (tmo_hit) err_d[0] = 1'b1;
    if (reply) begin
      err_d[3:1] = err_d[3:1] | rsp_err;
      rtype_d    = rsp_type;
      rcnt_d     = rsp_cnt;
      if (rsp_type == RT_NATIVE_ACK) rx_d = rsp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lm1_q   <= '0;
      cmd_q   <= '0;
      aonly_q <= 1'b0;
      addr_q  <= '0;
      tmo_q   <= TMO_W'(TMO_RST);
      tx_q    <= '0;
      rx_q    <= '0;
      err_q   <= '0;
      rtype_q <= '0;
      rcnt_q  <= '0;
      en_q    <= '0;
    end else begin
      lm1_q   <= lm1_d;
      cmd_q   <= cmd_d;
      aonly_q <= aonly_d;
      addr_q  <= addr_d;
      tmo_q   <= tmo_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      err_q   <= err_d;
      rtype_q <= rtype_d;
      rcnt_q  <= rcnt_d;
      en_q    <= en_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[LEN_W-1:0]      = lm1_q;
        bus_rdata[CTRL_AONLY]     = aonly_q;
        bus_rdata[CTRL_CMD +: 4]  = cmd_q;
        bus_rdata[CTRL_START]     = busy;
      end
      RA_ADDR: bus_rdata[ADDR_W-1:0] = addr_q;
      RA_STAT: begin
        bus_rdata[CNT_W-1:0]      = rcnt_q;
        bus_rdata[STAT_ERR +: 4]  = err_q;
        bus_rdata[STAT_TYPE +: 4] = rtype_q;
        bus_rdata[STAT_HPD]       = hpd_lvl;
      end
      RA_INT:  bus_rdata[N_INT-1:0] = pend;
      RA_EN:   bus_rdata[N_INT-1:0] = en_q;
      RA_TMO:  bus_rdata[TMO_W-1:0] = tmo_q;
      default: begin
        for (int i = 0; i < WORDS; i++) begin
          if (bus_addr == RA_W'(RA_TX0 + i)) bus_rdata = tx_q[i];
          if (bus_addr == RA_W'(RA_RX0 + i)) bus_rdata = rx_q[i];
        end
      end
    endcase
  end

  assign lnk_req  = busy;
  assign lnk_cmd  = cmd_q;
  assign lnk_addr = addr_q;
  assign lnk_len  = aonly_q ? '0 : CNT_W'(lm1_q) + 1'b1;
  assign lnk_tx   = tx_q;

  AST_LNK_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && $past(lnk_req)) |-> $stable(lnk_addr));  // R7
  AST_LNK_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_req && $past(lnk_req)) |-> $stable(lnk_tx));  // R7
endmodule

// File: tb/sim_auxc_host.sv
module sim_auxc_host;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic         hpd_in = 1'b0;
  logic         sink_evt = 1'b0;
  logic         lnk_req;
  logic [3:0]   lnk_cmd;
  logic [19:0]  lnk_addr;
  logic [4:0]   lnk_len;
  logic [127:0] lnk_tx;
  logic         rsp_valid = 1'b0;
  logic [3:0]   rsp_type = '0;
  logic [2:0]   rsp_err = '0;
  logic [4:0]   rsp_cnt = '0;
  logic [127:0] rsp_data = '0;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  auxc_host u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Drive a one-cycle reply; called at a negedge with lnk_req high
  task automatic reply(input logic [3:0] t, input logic [4:0] c,
                       input logic [2:0] e, input logic [127:0] d);
    rsp_valid = 1'b1; rsp_type = t; rsp_cnt = c; rsp_err = e; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_w(input logic [3:0] cmd, input logic ao,
                                         input logic [3:0] lm1);
    return 32'h1_0000 | (32'(cmd) << 12) | (32'(ao) << 8) | 32'(lm1);
  endfunction

  function automatic logic [4:0] exp_len(input logic ao, input logic [3:0] lm1);
    return ao ? 5'd0 : 5'(lm1) + 5'd1;
  endfunction

  function automatic logic [31:0] exp_stat(input logic h, input logic [3:0] t,
                                           input logic [3:0] e, input logic [4:0] c);
    return (32'(h) << 28) | (32'(t) << 16) | (32'(e) << 8) | 32'(c);
  endfunction

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [127:0] tx, rxm, rdat;
    logic [19:0] a;
    logic [3:0] lm1, cmd, t;
    logic ao;
    logic [4:0] c;
    void'($urandom(32'd1234));
    rxm = '0;

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, r); chk("R1 ctrl", r, 0);
    rd(4'd2, r); chk("R1 stat", r, 0);
    rd(4'd3, r); chk("R1 pend", r, 0);
    rd(4'd4, r); chk("R1 en", r, 0);
    rd(4'd5, r); chk("R1 tmo", r, 32'd1000);
    chk("R1 irq", irq, 0);
    chk("R1 lnk_req", lnk_req, 0);

    // R2 R3 full 16-byte native write
    tx = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
    for (int i = 0; i < 4; i++) wr(4'(8 + i), tx[32*i +: 32]);
    wr(4'd1, 32'h12345);
    wr(4'd0, ctrl_w(4'h8, 1'b0, 4'd15));
    chk("R2 lnk_req", lnk_req, 1);
    chk("R2 lnk_len", lnk_len, 5'd16);
    chk("R2 lnk_cmd", lnk_cmd, 4'h8);
    chk("R2 lnk_addr", lnk_addr, 20'h12345);
    chk("R3 byte0", lnk_tx[7:0], 8'h00);
    chk("R3 byte9", lnk_tx[79:72], 8'h09);
    chk("R3 tx", lnk_tx, tx);
    rd(4'd0, r); chk("R2 start reads busy", r[16], 1);
    // R7 writes ignored while busy
    wr(4'd1, 32'h0aaaa);
    wr(4'd8, 32'hdeadbeef);
    wr(4'd0, ctrl_w(4'h1, 1'b1, 4'd2));
    wr(4'd5, 32'd3);
    chk("R7 addr held", lnk_addr, 20'h12345);
    chk("R7 tx held", lnk_tx, tx);
    chk("R7 cmd held", lnk_cmd, 4'h8);
    chk("R7 len held", lnk_len, 5'd16);
    rd(4'd5, r); chk("R7 tmo held", r, 32'd1000);
    reply(4'h0, 5'd0, 3'b000, '0);
    chk("R2 req drops", lnk_req, 0);
    rd(4'd0, r); chk("R2 start clears", r[16], 0);
    rd(4'd3, r); chk("R8 done set", r[0], 1);
    chk("R9 irq masked", irq, 0);
    wr(4'd4, 32'h1);
    chk("R9 irq enabled", irq, 1);
    wr(4'd3, 32'h1);
    rd(4'd3, r); chk("R8 w1c", r, 0);
    chk("R9 irq clear", irq, 0);

    // R2 address-only
    wr(4'd0, ctrl_w(4'h1, 1'b1, 4'd7));
    chk("R2 addr-only len", lnk_len, 5'd0);
    chk("R2 addr-only cmd", lnk_cmd, 4'h1);
    reply(4'h0, 5'd0, 3'b000, '0);

    // R4 acked read then refused read
    rdat = 128'h11223344_55667788_99aabbcc_ddeeff00;
    wr(4'd0, ctrl_w(4'h9, 1'b0, 4'd15));
    reply(4'h0, 5'd16, 3'b000, rdat);
    rxm = rdat;
    for (int i = 0; i < 4; i++) begin
      rd(4'(12 + i), r); chk("R4 rx ack", r, rxm[32*i +: 32]);
    end
    rd(4'd2, r); chk("R4 stat ack", r, exp_stat(0, 4'h0, 4'h0, 5'd16));
    wr(4'd0, ctrl_w(4'h9, 1'b0, 4'd3));
    reply(4'h4, 5'd2, 3'b000, ~rdat);
    rd(4'd12, r); chk("R4 rx kept on I2C NACK", r, rxm[31:0]);
    rd(4'd2, r); chk("R4 stat nack", r, exp_stat(0, 4'h4, 4'h0, 5'd2));

    // R5 error flags
    wr(4'd0, ctrl_w(4'h9, 1'b0, 4'd0));
    reply(4'h2, 5'd0, 3'b101, '0);
    rd(4'd2, r); chk("R5 err set", r[11:8], 4'b1010);
    wr(4'd2, 32'h200);
    rd(4'd2, r); chk("R5 w1c one", r[11:8], 4'b1000);
    wr(4'd2, 32'hf00);
    rd(4'd2, r); chk("R5 clear all", r[11:8], 4'b0000);

    // R6 timeout
    wr(4'd3, 32'hf);
    wr(4'd5, 32'd5);
    wr(4'd0, ctrl_w(4'h0, 1'b0, 4'd0));
    chk("R6 req up", lnk_req, 1);
    repeat (10) @(negedge clk);
    chk("R6 req down", lnk_req, 0);
    rd(4'd2, r); chk("R6 tmo flag", r[8], 1);
    rd(4'd3, r); chk("R6 done", r[0], 1);
    wr(4'd2, 32'hf00);
    wr(4'd3, 32'hf);
    wr(4'd5, 32'd1000);

    // R10 hot plug
    @(negedge clk) hpd_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd2, r); chk("R10 hpd level", r[28], 1);
    rd(4'd3, r); chk("R10 plug", r, 32'h4);
    @(negedge clk) hpd_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd2, r); chk("R10 hpd low", r[28], 0);
    rd(4'd3, r); chk("R10 unplug", r, 32'hc);
    wr(4'd4, 32'h8);
    chk("R9 irq unplug", irq, 1);
    wr(4'd3, 32'hc);
    wr(4'd4, 32'h0);

    // R11 sink event
    @(negedge clk) sink_evt = 1'b1;
    @(negedge clk) sink_evt = 1'b0;
    rd(4'd3, r); chk("R11 sink", r, 32'h2);
    wr(4'd3, 32'h2);

    // Random transactions R2 R3 R4
    for (int k = 0; k < 40; k++) begin
      lm1 = 4'($urandom); cmd = 4'($urandom); ao = ($urandom % 4) == 0;
      a = 20'($urandom);
      tx = {$urandom, $urandom, $urandom, $urandom};
      for (int i = 0; i < 4; i++) wr(4'(8 + i), tx[32*i +: 32]);
      wr(4'd1, 32'(a));
      wr(4'd0, ctrl_w(cmd, ao, lm1));
      chk("R2 rnd len", lnk_len, exp_len(ao, lm1));
      chk("R2 rnd cmd", lnk_cmd, cmd);
      chk("R2 rnd addr", lnk_addr, a);
      chk("R3 rnd tx", lnk_tx, tx);
      case ($urandom % 5)
        0, 1:    t = 4'h0;
        2:       t = 4'h1;
        3:       t = 4'h2;
        default: t = 4'h8;
      endcase
      c = 5'($urandom % 17);
      rdat = {$urandom, $urandom, $urandom, $urandom};
      reply(t, c, 3'b000, rdat);
      if (t == 4'h0) rxm = rdat;
      rd(4'd2, r); chk("R4 rnd stat", r, exp_stat(0, t, 4'h0, c));
      for (int i = 0; i < 4; i++) begin
        rd(4'(12 + i), r); chk("R4 rnd rx", r, rxm[32*i +: 32]);
      end
    end

    finish_run();
  end
endmodule